// File: doc/BRIEF.md
# Wide-Port Wavefront Execution Engine

This block runs four-element wavefront instructions of the form `dst = f(src1, src2, src3)` on one 32-bit ALU. The register file has a single 128-bit port, and that port makes exactly one access per cycle: either a read or a write. Each instruction therefore spends three port cycles loading its three 128-bit operands into wide staging buffers, in the order src3, src2, src1. In each of the next four cycles the ALU takes one 32-bit slice of every operand. The finished 128-bit result is written back whole, in one port cycle.

Time is divided into 4-cycle slots. In the first cycle of a slot the port writes back the result of the wavefront that finished executing. In the remaining three cycles the port reads the operands of the wavefront accepted at the start of the slot. Meanwhile the ALU executes the wavefront whose operands were read in the previous slot. Operand and result staging are double-buffered, so one instruction completes every four cycles.

A side port lets a host preload or inspect registers whenever the engine is not using the register port in that cycle. A write-back observation port shows every result as it is written.

Top module: `wsimd_engine`

## Requirements
- R1: After reset, `wb_vld` and `dbg_rvld` are low, and no write-back occurs until an instruction has been accepted.
- R2: The opcode on `in_op` selects the per-element operation: 0 is src1+src2, 1 is src1-src2, 2 is AND, 3 is OR, 4 is XOR, 5 is the low 32 bits of src1*src2, 6 is multiply-add, and 7 passes src1 through. Every opcode other than 6 ignores src3.
- R3: Opcode 6 produces src1*src2+src3 in each element, modulo 2^32.
- R4: `in_rdy` is high only in the first cycle of a 4-cycle slot, so two cycles with `in_rdy` high are always a multiple of 4 cycles apart. An instruction is accepted in a cycle where `in_vld` and `in_rdy` are both high.
- R5: An accepted instruction writes all 128 bits of its destination in one cycle. `wb_vld`, `wb_idx` and `wb_data` present that write 8 cycles after the acceptance cycle.
- R6: Independent instructions offered back to back are accepted 4 cycles apart and all produce correct results, even while one wavefront's operands are being read and the previous one is executing.
- R7: An instruction that reads the destination of the immediately preceding instruction is held off for one extra slot. It is accepted 8 cycles after its predecessor and sees the updated value.
- R8: The debug port is granted (`dbg_rdy` high) only in cycles when the engine is not using the register port. `dbg_rdy` is low in the three cycles after an acceptance. A granted write stores all 128 bits. A granted read returns the data on `dbg_rdata`, with `dbg_rvld` high, in the next cycle.
- R9: Element k occupies bits [32k+31:32k]. Each element is computed independently, and no carry or borrow crosses between elements.
- R10: Addition, subtraction and multiplication wrap modulo 2^32 in each element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Instruction offered |
| in_rdy | output | 1 | Instruction can be accepted this cycle |
| in_op | input | 3 | Operation code |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| in_src3 | input | 4 | Third source register (addend for multiply-add) |
| dbg_vld | input | 1 | Debug access requested |
| dbg_rdy | output | 1 | Register port is free for a debug access this cycle |
| dbg_we | input | 1 | Debug access is a write |
| dbg_idx | input | 4 | Debug register index |
| dbg_wdata | input | 128 | Debug write data |
| dbg_rdata | output | 128 | Debug read data |
| dbg_rvld | output | 1 | `dbg_rdata` holds the result of the read granted in the previous cycle |
| wb_vld | output | 1 | A result is being written back this cycle |
| wb_idx | output | 4 | Register being written back |
| wb_data | output | 128 | Result being written back |

## Verification
The assertions assume the host requests debug accesses only through the `dbg_vld`/`dbg_rdy` handshake. They also assume `in_vld` is low while reset is asserted, so every acceptance they see is followed by its write-back eight cycles later. The stimulus keeps within these limits. Debug accesses are made only when the engine is idle, all inputs change at the falling edge, and each offer is held until it is accepted. Random streams choose registers freely, so read-after-write stalls occur naturally and stay legal.

// File: rtl/wsimd_pkg.sv
`timescale 1ns/1ps
package wsimd_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_MUL  = 3'd5,
    OP_MAD  = 3'd6,
    OP_PASS = 3'd7
  } wop_e;
endpackage

// File: rtl/wsimd_regfile.sv
`timescale 1ns/1ps
module wsimd_regfile #(
  parameter int WW   = 128,
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [WW-1:0] wdata,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem_q [NREG];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/wsimd_alu.sv
`timescale 1ns/1ps
module wsimd_alu
  import wsimd_pkg::*;
#(
  parameter int EW = 32
) (
  input  wop_e          op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic [EW-1:0] c,
  output logic [EW-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_MUL:  y = a * b;
      OP_MAD:  y = a * b + c;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/wsimd_stager.sv
`timescale 1ns/1ps
module wsimd_stager #(
  parameter int EW    = 32,
  parameter int LANES = 4,
  parameter int PW    = $clog2(LANES),
  parameter int WW    = EW * LANES
) (
  input  logic          clk,
  input  logic          cap_en,
  input  logic [1:0]    cap_sel,
  input  logic          bank,
  input  logic [WW-1:0] rf_rdata,
  input  logic          ex_en,
  input  logic [PW-1:0] lane,
  input  logic [EW-1:0] alu_y,
  output logic [EW-1:0] opa,
  output logic [EW-1:0] opb,
  output logic [EW-1:0] opc,
  output logic [WW-1:0] wb_word
);
  localparam int NSRC = 3;

  logic [EW-1:0] slice [NSRC];
  logic [WW-1:0] dst_q [2];

  // operand staging: index 0 = src1, 1 = src2, 2 = src3; two banks each
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [WW-1:0] buf_q [2];
    always_ff @(posedge clk) begin
      if (cap_en && (cap_sel == 2'(s))) buf_q[bank] <= rf_rdata;
    end
    assign slice[s] = buf_q[~bank][int'(lane)*EW +: EW];
  end

  assign opa = slice[0];
  assign opb = slice[1];
  assign opc = slice[2];

  // result assembly: executing wavefront fills bank, write-back drains ~bank
  always_ff @(posedge clk) begin
    if (ex_en) dst_q[bank][int'(lane)*EW +: EW] <= alu_y;
  end

  assign wb_word = dst_q[~bank];
endmodule

// File: rtl/wsimd_ctrl.sv
`timescale 1ns/1ps
module wsimd_ctrl
  import wsimd_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int LANES = 4,
  parameter int IW    = $clog2(NREG),
  parameter int PW    = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  output logic          in_rdy,
  input  logic [2:0]    in_op,
  input  logic [IW-1:0] in_dst,
  input  logic [IW-1:0] in_s1,
  input  logic [IW-1:0] in_s2,
  input  logic [IW-1:0] in_s3,
  output logic [PW-1:0] ph,
  output logic          bank,
  output logic          rd_en,
  output logic [1:0]    cap_sel,
  output logic [IW-1:0] rd_idx,
  output logic          ex_en,
  output wop_e          ex_op,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic          port_free
);
  localparam logic [PW-1:0] LAST = PW'(LANES - 1);

  logic          run_q, run_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          bank_q, bank_d;
  logic          rd_v_q, rd_v_d;
  wop_e          rd_op_q, rd_op_d;
  logic [IW-1:0] rd_dst_q, rd_dst_d, rd_s1_q, rd_s1_d, rd_s2_q, rd_s2_d, rd_s3_q, rd_s3_d;
  logic          ex_v_q, ex_v_d;
  wop_e          ex_op_q, ex_op_d;
  logic [IW-1:0] ex_dst_q, ex_dst_d;
  logic          wb_v_q, wb_v_d;
  logic [IW-1:0] wb_dst_q, wb_dst_d;
  logic          raw, acc;

  assign raw    = ex_v_q && ((ex_dst_q == in_s1) || (ex_dst_q == in_s2) || (ex_dst_q == in_s3));
  assign in_rdy = run_q && (ph_q == '0) && !raw;
  assign acc    = in_vld && in_rdy;

  always_comb begin
    run_d    = 1'b1;
    ph_d     = (ph_q == LAST) ? '0 : ph_q + 1'b1;
    bank_d   = bank_q;
    rd_v_d   = rd_v_q;
    rd_op_d  = rd_op_q;
    rd_dst_d = rd_dst_q;
    rd_s1_d  = rd_s1_q;
    rd_s2_d  = rd_s2_q;
    rd_s3_d  = rd_s3_q;
    ex_v_d   = ex_v_q;
    ex_op_d  = ex_op_q;
    ex_dst_d = ex_dst_q;
    wb_v_d   = wb_v_q;
    wb_dst_d = wb_dst_q;
    if (ph_q == LAST) begin
      bank_d   = ~bank_q;
      ex_v_d   = rd_v_q;
      ex_op_d  = rd_op_q;
      ex_dst_d = rd_dst_q;
      wb_v_d   = ex_v_q;
      wb_dst_d = ex_dst_q;
      rd_v_d   = 1'b0;
    end
    if (ph_q == '0) begin
      rd_v_d = acc;
      if (acc) begin
        rd_op_d  = wop_e'(in_op);
        rd_dst_d = in_dst;
        rd_s1_d  = in_s1;
        rd_s2_d  = in_s2;
        rd_s3_d  = in_s3;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ph_q     <= '0;
      bank_q   <= 1'b0;
      rd_v_q   <= 1'b0;
      rd_op_q  <= OP_ADD;
      rd_dst_q <= '0;
      rd_s1_q  <= '0;
      rd_s2_q  <= '0;
      rd_s3_q  <= '0;
      ex_v_q   <= 1'b0;
      ex_op_q  <= OP_ADD;
      ex_dst_q <= '0;
      wb_v_q   <= 1'b0;
      wb_dst_q <= '0;
    end else begin
      run_q    <= run_d;
      ph_q     <= ph_d;
      bank_q   <= bank_d;
      rd_v_q   <= rd_v_d;
      rd_op_q  <= rd_op_d;
      rd_dst_q <= rd_dst_d;
      rd_s1_q  <= rd_s1_d;
      rd_s2_q  <= rd_s2_d;
      rd_s3_q  <= rd_s3_d;
      ex_v_q   <= ex_v_d;
      ex_op_q  <= ex_op_d;
      ex_dst_q <= ex_dst_d;
      wb_v_q   <= wb_v_d;
      wb_dst_q <= wb_dst_d;
    end
  end

  // port schedule: phase 0 writes back, phases 1..3 read src3, src2, src1
  always_comb begin
    unique case (ph_q)
      2'd1:    begin cap_sel = 2'd2; rd_idx = rd_s3_q; end
      2'd2:    begin cap_sel = 2'd1; rd_idx = rd_s2_q; end
      default: begin cap_sel = 2'd0; rd_idx = rd_s1_q; end
    endcase
  end

  assign ph        = ph_q;
  assign bank      = bank_q;
  assign rd_en     = rd_v_q && (ph_q != '0);
  assign ex_en     = ex_v_q;
  assign ex_op     = ex_op_q;
  assign wb_en     = wb_v_q && (ph_q == '0);
  assign wb_idx    = wb_dst_q;
  assign port_free = (ph_q == '0) ? !wb_v_q : !rd_v_q;

  // R4
  rdy_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy |=> !in_rdy);

  // R7
  raw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_v_q && ex_v_q) |-> ((ex_dst_q != rd_s1_q) && (ex_dst_q != rd_s2_q) && (ex_dst_q != rd_s3_q)));

  // R5
  wb_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ##8 (wb_en && (wb_idx == $past(in_dst, 8))));
endmodule

// File: rtl/wsimd_engine.sv
`timescale 1ns/1ps
module wsimd_engine
  import wsimd_pkg::*;
#(
  parameter int EW    = 32,
  parameter int LANES = 4,
  parameter int NREG  = 16,
  parameter int WW    = EW * LANES,
  parameter int IW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  output logic          in_rdy,
  input  logic [2:0]    in_op,
  input  logic [IW-1:0] in_dst,
  input  logic [IW-1:0] in_src1,
  input  logic [IW-1:0] in_src2,
  input  logic [IW-1:0] in_src3,
  input  logic          dbg_vld,
  output logic          dbg_rdy,
  input  logic          dbg_we,
  input  logic [IW-1:0] dbg_idx,
  input  logic [WW-1:0] dbg_wdata,
  output logic [WW-1:0] dbg_rdata,
  output logic          dbg_rvld,
  output logic          wb_vld,
  output logic [IW-1:0] wb_idx,
  output logic [WW-1:0] wb_data
);
  localparam int PW = $clog2(LANES);

  logic [1:0]    sync_q;
  logic          rst_n_s;
  logic [PW-1:0] ph;
  logic          bank, rd_en, ex_en, wb_en, port_free, dbg_gnt;
  logic [1:0]    cap_sel;
  logic [IW-1:0] rd_idx, wb_dst;
  wop_e          ex_op;
  logic          port_we;
  logic [IW-1:0] port_idx;
  logic [WW-1:0] port_wdata, port_rdata, wb_word;
  logic [EW-1:0] opa, opb, opc, alu_y;
  logic          rvld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_s = sync_q[1];

  wsimd_ctrl #(.NREG(NREG), .LANES(LANES), .IW(IW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .in_vld(in_vld), .in_rdy(in_rdy), .in_op(in_op),
    .in_dst(in_dst), .in_s1(in_src1), .in_s2(in_src2), .in_s3(in_src3),
    .ph(ph), .bank(bank), .rd_en(rd_en), .cap_sel(cap_sel), .rd_idx(rd_idx),
    .ex_en(ex_en), .ex_op(ex_op), .wb_en(wb_en), .wb_idx(wb_dst), .port_free(port_free)
  );

  assign dbg_rdy    = port_free;
  assign dbg_gnt    = dbg_vld && port_free;
  assign port_we    = wb_en || (dbg_gnt && dbg_we);
  assign port_idx   = wb_en ? wb_dst : (rd_en ? rd_idx : dbg_idx);
  assign port_wdata = wb_en ? wb_word : dbg_wdata;

  wsimd_regfile #(.WW(WW), .NREG(NREG), .IW(IW)) u_rf (
    .clk(clk), .we(port_we), .idx(port_idx), .wdata(port_wdata), .rdata(port_rdata)
  );

  wsimd_stager #(.EW(EW), .LANES(LANES), .PW(PW), .WW(WW)) u_stage (
    .clk(clk), .cap_en(rd_en), .cap_sel(cap_sel), .bank(bank), .rf_rdata(port_rdata),
    .ex_en(ex_en), .lane(ph), .alu_y(alu_y), .opa(opa), .opb(opb), .opc(opc), .wb_word(wb_word)
  );

  wsimd_alu #(.EW(EW)) u_alu (.op(ex_op), .a(opa), .b(opb), .c(opc), .y(alu_y));

  assign rvld_d = dbg_gnt && !dbg_we;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) dbg_rvld <= 1'b0;
    else          dbg_rvld <= rvld_d;
  end

  always_ff @(posedge clk) begin
    if (rvld_d) dbg_rdata <= port_rdata;
  end

  assign wb_vld  = wb_en;
  assign wb_idx  = wb_dst;
  assign wb_data = wb_word;

  // R8
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({wb_en, rd_en, dbg_gnt}));

  // R8
  dbg_rvld_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    dbg_rvld |-> $past(dbg_vld && dbg_rdy && !dbg_we));
endmodule

// File: tb/wsimd_engine_tb.sv
`timescale 1ns/1ps
module wsimd_engine_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_vld, in_rdy;
  logic [2:0]   in_op;
  logic [3:0]   in_dst, in_src1, in_src2, in_src3;
  logic         dbg_vld, dbg_rdy, dbg_we, dbg_rvld;
  logic [3:0]   dbg_idx;
  logic [127:0] dbg_wdata, dbg_rdata;
  logic         wb_vld;
  logic [3:0]   wb_idx;
  logic [127:0] wb_data;

  always #2.5 clk = ~clk;

  wsimd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_src3(in_src3),
    .dbg_vld(dbg_vld), .dbg_rdy(dbg_rdy), .dbg_we(dbg_we), .dbg_idx(dbg_idx),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .dbg_rvld(dbg_rvld),
    .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  typedef struct packed {
    logic [3:0]   idx;
    logic [127:0] data;
    logic [31:0]  cyc;
  } exp_t;

  exp_t         expq [$];
  string        tagq [$];
  logic [127:0] mreg [16];
  int           total = 0, bad = 0, cyc = 0;
  int           last_acc = 0, last_gap = 0;
  int           last_rdy = -1;
  bit           rdy_bad = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [2:0] op, input logic [127:0] a,
                                          input logic [127:0] b, input logic [127:0] c);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] x, y, z, o;
      x = a[32*k +: 32]; y = b[32*k +: 32]; z = c[32*k +: 32];
      case (op)
        3'd0: o = x + y;
        3'd1: o = x - y;
        3'd2: o = x & y;
        3'd3: o = x | y;
        3'd4: o = x ^ y;
        3'd5: o = x * y;
        3'd6: o = x * y + z;
        default: o = x;
      endcase
      r[32*k +: 32] = o;
    end
    return r;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [3:0] d, input logic [3:0] s1,
                       input logic [3:0] s2, input logic [3:0] s3, input string tag);
    logic [127:0] r;
    @(negedge clk);
    in_vld = 1'b1; in_op = op; in_dst = d; in_src1 = s1; in_src2 = s2; in_src3 = s3;
    #1;
    while (!in_rdy) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_vld = 1'b0;
    r = model(op, mreg[s1], mreg[s2], mreg[s3]);
    mreg[d] = r;
    last_gap = cyc - last_acc;
    last_acc = cyc;
    expq.push_back({d, r, 32'(cyc + 7)});
    tagq.push_back(tag);
  endtask

  task automatic dbg_wr(input logic [3:0] i, input logic [127:0] v);
    @(negedge clk);
    dbg_vld = 1'b1; dbg_we = 1'b1; dbg_idx = i; dbg_wdata = v;
    #1;
    while (!dbg_rdy) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    dbg_vld = 1'b0; dbg_we = 1'b0;
    mreg[i] = v;
  endtask

  task automatic dbg_rd_chk(input logic [3:0] i);
    @(negedge clk);
    dbg_vld = 1'b1; dbg_we = 1'b0; dbg_idx = i;
    #1;
    while (!dbg_rdy) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    dbg_vld = 1'b0;
    @(negedge clk);
    check(dbg_rvld == 1'b1, "R8 dbg_rvld after read", 128'(dbg_rvld), 128'(1));
    check(dbg_rdata == mreg[i], "R8 dbg read data", dbg_rdata, mreg[i]);
  endtask

  task automatic drain;
    while (expq.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (in_rdy) begin
        if (last_rdy >= 0 && ((cyc - last_rdy) % 4) != 0) rdy_bad = 1'b1;
        last_rdy = cyc;
      end
      if (wb_vld) begin
        if (expq.size() == 0) begin
          check(1'b0, "R1/R5 unexpected write-back", wb_data, 128'(0));
        end else begin
          exp_t  e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(wb_idx == e.idx, {t, " R5 wb_idx"}, 128'(wb_idx), 128'(e.idx));
          check(wb_data == e.data, {t, " wb_data"}, wb_data, e.data);
          check(cyc == int'(e.cyc), {t, " R5 write-back cycle"}, 128'(cyc), 128'(e.cyc));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_op = '0; in_dst = '0; in_src1 = '0; in_src2 = '0; in_src3 = '0;
    dbg_vld = 1'b0; dbg_we = 1'b0; dbg_idx = '0; dbg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(wb_vld == 1'b0, "R1 wb_vld after reset", 128'(wb_vld), 128'(0));
    check(dbg_rvld == 1'b0, "R1 dbg_rvld after reset", 128'(dbg_rvld), 128'(0));

    // R8 preload through debug port
    for (int i = 0; i < 16; i++) dbg_wr(4'(i), {$urandom, $urandom, $urandom, $urandom});
    dbg_wr(4'd1, {32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF});
    dbg_wr(4'd2, {32'h0000_0001, 32'h0000_0001, 32'h8000_0000, 32'h0000_0001});
    dbg_wr(4'd3, {32'h0000_0005, 32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFE});
    dbg_rd_chk(4'd1);
    dbg_rd_chk(4'd7);

    // R2 every opcode, R9/R10 wrap and lane isolation, R3 multiply-add
    issue(3'd0, 4'd4, 4'd1, 4'd2, 4'd3, "R10 R9 add wrap");
    drain();
    issue(3'd1, 4'd5, 4'd2, 4'd1, 4'd3, "R10 R9 sub borrow");
    drain();
    issue(3'd2, 4'd6, 4'd1, 4'd3, 4'd2, "R2 and");
    issue(3'd3, 4'd7, 4'd1, 4'd3, 4'd2, "R2 or");
    issue(3'd4, 4'd8, 4'd1, 4'd3, 4'd2, "R2 xor");
    issue(3'd5, 4'd9, 4'd1, 4'd3, 4'd2, "R10 mul low bits");
    issue(3'd6, 4'd10, 4'd1, 4'd3, 4'd2, "R3 multiply-add");
    issue(3'd7, 4'd11, 4'd3, 4'd1, 4'd2, "R2 pass src1");
    drain();

    // R2 two-input op ignores src3: same op with different src3 gives same result
    issue(3'd0, 4'd12, 4'd1, 4'd2, 4'd3, "R2 add src3=r3");
    issue(3'd0, 4'd13, 4'd1, 4'd2, 4'd9, "R2 add src3=r9");
    drain();
    check(mreg[12] == mreg[13], "R2 src3 ignored model sanity", mreg[13], mreg[12]);

    // R6 back-to-back independent, R8 port busy during reads
    issue(3'd6, 4'd14, 4'd1, 4'd2, 4'd3, "R6 first");
    begin
      bit busy_ok = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (dbg_rdy) busy_ok = 1'b0;
      end
      check(busy_ok, "R8 dbg_rdy low during operand reads", 128'(!busy_ok), 128'(0));
    end
    issue(3'd0, 4'd15, 4'd6, 4'd7, 4'd8, "R6 second");
    check(last_gap == 4, "R6 accept spacing", 128'(last_gap), 128'(4));
    issue(3'd4, 4'd0, 4'd9, 4'd10, 4'd11, "R6 third");
    check(last_gap == 4, "R6 accept spacing", 128'(last_gap), 128'(4));
    drain();

    // R7 dependent on immediately preceding destination
    issue(3'd0, 4'd5, 4'd1, 4'd2, 4'd3, "R7 producer");
    issue(3'd5, 4'd6, 4'd5, 4'd3, 4'd0, "R7 consumer");
    check(last_gap == 8, "R7 stall one slot", 128'(last_gap), 128'(8));
    issue(3'd6, 4'd7, 4'd2, 4'd3, 4'd6, "R7 consumer via src3");
    check(last_gap == 8, "R7 stall on src3", 128'(last_gap), 128'(8));
    drain();

    // random stream
    for (int n = 0; n < 60; n++)
      issue(3'($urandom % 8), 4'($urandom % 16), 4'($urandom % 16), 4'($urandom % 16),
            4'($urandom % 16), "R6 R7 random");
    drain();

    check(!rdy_bad, "R4 in_rdy slot spacing", 128'(rdy_bad), 128'(0));
    for (int i = 0; i < 16; i++) dbg_rd_chk(4'(i));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule